// File: doc/BRIEF.md
# Display Timing Generator With Shadow Load

This block produces the raster timing for a parallel RGB panel from a pixel clock: horizontal sync, vertical sync, data enable and the x/y position of the current active pixel. Each axis is described by four fields: active size, front porch, sync pulse width and back porch. Within a line the order is active, front porch, sync, back porch. Frames are built the same way from lines, and the line counter advances once at the end of each line. The counters cover up to 4095 positions per axis.

All timing fields, the three output polarity controls and the falling-edge data select arrive on configuration pins that act as shadow copies. They reach the working set only at a frame boundary, and only while a load request is pending. A load request is raised by a one-cycle pulse and clears itself when it is consumed. The enable pin starts the raster at once but stops it only at the end of the frame in progress, and the enable status output reports this. A separate display-on pin gates data enable. A vertical-blank pulse drives a sticky, write-one-to-clear status with a maskable interrupt. A synchronous software reset input returns all state to its defaults.

There is no data stream through the block. All pins are plain level or pulse controls, so no valid/ready handshake or back-pressure applies.

Top module: `disp_timing_gen`

## Requirements
- R1: While running, line position h counts from 0 to HA+HF+HS+HB-1 and then wraps to 0. The hsync condition is true for HA+HF <= h < HA+HF+HS.
- R2: The line counter v advances only when h wraps, and counts from 0 to VA+VF+VS+VB-1. The vsync condition is true for VA+VF <= v < VA+VF+VS.
- R3: de is active only when running, display_on=1, h<HA and v<VA. While de is active, pix_x=h and pix_y=v. While de is inactive, both pix_x and pix_y are 0.
- R4: Polarity controls work per output. A working-set invert bit of 1 makes hsync, vsync or de low while its condition is active and high otherwise. The falling-edge select output equals its working-set bit.
- R5: A shadow_load pulse sets load_pending. At a frame boundary with load_pending=1, the working set takes all cfg_* values and load_pending clears. A frame boundary is the last cycle of a frame, or the start cycle from idle. A request in the same cycle as a load stays pending. cfg_* changes have no effect otherwise.
- R6: With the generator idle, enable=1 sets en_status in the next cycle. The frame then begins at h=0, v=0.
- R7: Clearing enable while running lets the current frame finish. en_status stays 1 until the cycle after the last pixel of the frame, then drops to 0. All outputs then rest at their inactive levels.
- R8: vb_pulse is 1 for exactly one cycle per frame, at h=0 of line v=VA.
- R9: vb_status is set by vb_pulse and cleared by vb_clr=1. Set wins over clear. vb_irq is 1 exactly when vb_status=1 and vb_irq_en=1.
- R10: soft_rst=1 at a clock edge stops the generator and clears load_pending and vb_status. It also restores the default working set: 640/16/96/48 horizontal, 480/10/2/33 vertical, no inversion.
- R11: After rst_n goes low, en_status, load_pending, vb_status, hsync, vsync and de are 0.
- R12: An active width of 4095 is supported. pix_x reaches 4094 within such a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | asynchronous reset, active low |
| soft_rst | input | 1 | synchronous software reset |
| enable | input | 1 | run request |
| display_on | input | 1 | gate for data enable |
| shadow_load | input | 1 | pulse: request working-set load at next frame boundary |
| cfg_h_active | input | 12 | shadow horizontal active width |
| cfg_h_fp | input | 12 | shadow horizontal front porch |
| cfg_h_sync | input | 12 | shadow hsync width |
| cfg_h_bp | input | 12 | shadow horizontal back porch |
| cfg_v_active | input | 12 | shadow active line count |
| cfg_v_fp | input | 12 | shadow vertical front porch |
| cfg_v_sync | input | 12 | shadow vsync width in lines |
| cfg_v_bp | input | 12 | shadow vertical back porch |
| cfg_hs_inv | input | 1 | shadow hsync invert |
| cfg_vs_inv | input | 1 | shadow vsync invert |
| cfg_de_inv | input | 1 | shadow data enable invert |
| cfg_fall_edge | input | 1 | shadow falling-edge data select |
| vb_irq_en | input | 1 | vertical-blank interrupt enable |
| vb_clr | input | 1 | write-one clear of vb_status |
| hsync | output | 1 | horizontal sync |
| vsync | output | 1 | vertical sync |
| de | output | 1 | data enable |
| pix_x | output | 12 | active pixel column |
| pix_y | output | 12 | active pixel row |
| fall_edge | output | 1 | working falling-edge data select |
| en_status | output | 1 | generator running |
| load_pending | output | 1 | shadow load outstanding |
| vb_pulse | output | 1 | vertical-blank event |
| vb_status | output | 1 | sticky vertical-blank status |
| vb_irq | output | 1 | vertical-blank interrupt |

## Verification
Two corner cases are hard to reach from the pins. One is a disable that arrives in mid-frame, where the generator must keep running to the exact last pixel. The other is a shadow load that is requested while the old configuration is still scanning. The stimulus changes the cfg pins and drops enable at random points within a frame. It relies on a cycle model in the bench to know where the frame boundary falls. Only a small active width is used, so that many frames, and therefore many boundaries, fit in the run. One long 4095-wide line then covers the counter limit.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int DTG_CNT_W = 12;
  localparam int DTG_TOT_W = DTG_CNT_W + 2;

  typedef struct packed {
    logic [DTG_CNT_W-1:0] active;
    logic [DTG_CNT_W-1:0] fp;
    logic [DTG_CNT_W-1:0] sync;
    logic [DTG_CNT_W-1:0] bp;
  } axis_cfg_t;

  typedef struct packed {
    axis_cfg_t h;
    axis_cfg_t v;
    logic      hs_inv;
    logic      vs_inv;
    logic      de_inv;
    logic      fall_edge;
  } tim_cfg_t;
endpackage

// File: rtl/dtg_axis.sv
module dtg_axis
  import dtg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 adv,
  input  axis_cfg_t            cfg,
  output logic [DTG_TOT_W-1:0] cnt,
  output logic                 last,
  output logic                 in_active,
  output logic                 in_sync
);
  logic [DTG_TOT_W-1:0] sync_beg, sync_end, total;

  always_comb begin
    sync_beg = DTG_TOT_W'(cfg.active) + DTG_TOT_W'(cfg.fp);
    sync_end = sync_beg + DTG_TOT_W'(cfg.sync);
    total    = sync_end + DTG_TOT_W'(cfg.bp);
  end

  assign last      = (cnt == total - 1'b1);
  assign in_active = (cnt < DTG_TOT_W'(cfg.active));
  assign in_sync   = (cnt >= sync_beg) && (cnt < sync_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (adv)    cnt <= last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/dtg_shadow.sv
module dtg_shadow
  import dtg_pkg::*;
#(
  parameter tim_cfg_t DEFAULTS = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  logic     load_req,
  input  logic     boundary,
  input  tim_cfg_t cfg_in,
  output tim_cfg_t work,
  output logic     pending
);
  logic load_now;
  assign load_now = pending && boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      work    <= DEFAULTS;
    end else if (soft_rst) begin
      pending <= 1'b0;
      work    <= DEFAULTS;
    end else begin
      if (load_req)      pending <= 1'b1;
      else if (load_now) pending <= 1'b0;
      if (load_now)      work    <= cfg_in;
    end
  end
endmodule

// File: rtl/dtg_vblank.sv
module dtg_vblank (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic event_in,
  input  logic clr,
  input  logic irq_en,
  output logic status,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status <= 1'b0;
    else if (soft_rst)  status <= 1'b0;
    else if (event_in)  status <= 1'b1;
    else if (clr)       status <= 1'b0;
  end
  assign irq = status && irq_en;
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int DEF_H_ACTIVE = 640,
  parameter int DEF_H_FP     = 16,
  parameter int DEF_H_SYNC   = 96,
  parameter int DEF_H_BP     = 48,
  parameter int DEF_V_ACTIVE = 480,
  parameter int DEF_V_FP     = 10,
  parameter int DEF_V_SYNC   = 2,
  parameter int DEF_V_BP     = 33
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 enable,
  input  logic                 display_on,
  input  logic                 shadow_load,
  input  logic [DTG_CNT_W-1:0] cfg_h_active,
  input  logic [DTG_CNT_W-1:0] cfg_h_fp,
  input  logic [DTG_CNT_W-1:0] cfg_h_sync,
  input  logic [DTG_CNT_W-1:0] cfg_h_bp,
  input  logic [DTG_CNT_W-1:0] cfg_v_active,
  input  logic [DTG_CNT_W-1:0] cfg_v_fp,
  input  logic [DTG_CNT_W-1:0] cfg_v_sync,
  input  logic [DTG_CNT_W-1:0] cfg_v_bp,
  input  logic                 cfg_hs_inv,
  input  logic                 cfg_vs_inv,
  input  logic                 cfg_de_inv,
  input  logic                 cfg_fall_edge,
  input  logic                 vb_irq_en,
  input  logic                 vb_clr,
  output logic                 hsync,
  output logic                 vsync,
  output logic                 de,
  output logic [DTG_CNT_W-1:0] pix_x,
  output logic [DTG_CNT_W-1:0] pix_y,
  output logic                 fall_edge,
  output logic                 en_status,
  output logic                 load_pending,
  output logic                 vb_pulse,
  output logic                 vb_status,
  output logic                 vb_irq
);
  localparam tim_cfg_t DEFAULTS = '{
    h: '{active: DTG_CNT_W'(DEF_H_ACTIVE), fp: DTG_CNT_W'(DEF_H_FP),
         sync: DTG_CNT_W'(DEF_H_SYNC), bp: DTG_CNT_W'(DEF_H_BP)},
    v: '{active: DTG_CNT_W'(DEF_V_ACTIVE), fp: DTG_CNT_W'(DEF_V_FP),
         sync: DTG_CNT_W'(DEF_V_SYNC), bp: DTG_CNT_W'(DEF_V_BP)},
    hs_inv: 1'b0, vs_inv: 1'b0, de_inv: 1'b0, fall_edge: 1'b0};

  tim_cfg_t             cfg_in, work;
  logic                 running;
  logic [DTG_TOT_W-1:0] h_cnt, v_cnt;
  logic                 h_last, v_last, h_act, v_act, h_syn, v_syn;
  logic                 frame_end, start, boundary, de_raw, vb_event;

  assign cfg_in = '{
    h: '{active: cfg_h_active, fp: cfg_h_fp, sync: cfg_h_sync, bp: cfg_h_bp},
    v: '{active: cfg_v_active, fp: cfg_v_fp, sync: cfg_v_sync, bp: cfg_v_bp},
    hs_inv: cfg_hs_inv, vs_inv: cfg_vs_inv, de_inv: cfg_de_inv,
    fall_edge: cfg_fall_edge};

  assign frame_end = running && h_last && v_last;
  assign start     = !running && enable;
  assign boundary  = frame_end || start;

  // Run state: start immediately, stop only on the last pixel of a frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      running <= 1'b0;
    else if (soft_rst)               running <= 1'b0;
    else if (!running)               running <= enable;
    else if (frame_end && !enable)   running <= 1'b0;
  end

  dtg_shadow #(.DEFAULTS(DEFAULTS)) u_shadow (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .load_req(shadow_load),
    .boundary(boundary), .cfg_in(cfg_in), .work(work), .pending(load_pending));

  dtg_axis u_hax (
    .clk(clk), .rst_n(rst_n), .clr(!running || soft_rst), .adv(running),
    .cfg(work.h), .cnt(h_cnt), .last(h_last), .in_active(h_act), .in_sync(h_syn));

  dtg_axis u_vax (
    .clk(clk), .rst_n(rst_n), .clr(!running || soft_rst), .adv(running && h_last),
    .cfg(work.v), .cnt(v_cnt), .last(v_last), .in_active(v_act), .in_sync(v_syn));

  assign vb_event = running && (h_cnt == '0) && (v_cnt == DTG_TOT_W'(work.v.active));

  dtg_vblank u_vb (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .event_in(vb_event),
    .clr(vb_clr), .irq_en(vb_irq_en), .status(vb_status), .irq(vb_irq));

  assign de_raw    = running && display_on && h_act && v_act;
  assign de        = de_raw ^ work.de_inv;
  assign hsync     = (running && h_syn) ^ work.hs_inv;
  assign vsync     = (running && v_syn) ^ work.vs_inv;
  assign pix_x     = de_raw ? h_cnt[DTG_CNT_W-1:0] : '0;
  assign pix_y     = de_raw ? v_cnt[DTG_CNT_W-1:0] : '0;
  assign fall_edge = work.fall_edge;
  assign en_status = running;
  assign vb_pulse  = vb_event;
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
  import dtg_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 soft_rst,
  input logic                 enable,
  input logic                 display_on,
  input logic                 vb_clr,
  input logic                 de,
  input logic                 de_inv,
  input logic [DTG_CNT_W-1:0] pix_x,
  input logic [DTG_CNT_W-1:0] pix_y,
  input logic                 en_status,
  input logic                 load_pending,
  input logic                 frame_end,
  input logic                 vb_pulse,
  input logic                 vb_status
);
  assert_de_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !display_on |-> (de == de_inv));

  assert_pix_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (de == de_inv) |-> (pix_x == '0 && pix_y == '0));

  assert_stop_at_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_status) |-> ($past(frame_end) || $past(soft_rst)));

  assert_load_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_pending) |-> ($past(frame_end) || $past(soft_rst)
                             || ($past(!en_status) && $past(enable))));

  assert_vb_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vb_pulse |=> !vb_pulse);

  assert_vb_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_status && !vb_clr && !soft_rst) |=> vb_status);

  assert_vb_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vb_status) |-> $past(vb_pulse));
endmodule

bind disp_timing_gen dtg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
  .display_on(display_on), .vb_clr(vb_clr), .de(de), .de_inv(work.de_inv),
  .pix_x(pix_x), .pix_y(pix_y), .en_status(en_status),
  .load_pending(load_pending), .frame_end(frame_end), .vb_pulse(vb_pulse),
  .vb_status(vb_status));

// File: tb/sim_disp_timing_gen.sv
`timescale 1ns/1ps
module sim_disp_timing_gen;
  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, enable = 1'b0;
  logic display_on = 1'b1, shadow_load = 1'b0, vb_irq_en = 1'b0, vb_clr = 1'b0;
  logic [11:0] c_ha = 4, c_hf = 2, c_hs = 2, c_hb = 1;
  logic [11:0] c_va = 3, c_vf = 1, c_vs = 1, c_vb = 1;
  logic c_hsi = 0, c_vsi = 0, c_dei = 0, c_fe = 0;
  logic hsync, vsync, de, fall_edge, en_status, load_pending, vb_pulse, vb_status, vb_irq;
  logic [11:0] pix_x, pix_y;

  int n_chk = 0, n_fail = 0, max_x = 0;
  bit track_x = 0;

  always #2.5 clk = ~clk;

  disp_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
    .display_on(display_on), .shadow_load(shadow_load),
    .cfg_h_active(c_ha), .cfg_h_fp(c_hf), .cfg_h_sync(c_hs), .cfg_h_bp(c_hb),
    .cfg_v_active(c_va), .cfg_v_fp(c_vf), .cfg_v_sync(c_vs), .cfg_v_bp(c_vb),
    .cfg_hs_inv(c_hsi), .cfg_vs_inv(c_vsi), .cfg_de_inv(c_dei), .cfg_fall_edge(c_fe),
    .vb_irq_en(vb_irq_en), .vb_clr(vb_clr),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
    .fall_edge(fall_edge), .en_status(en_status), .load_pending(load_pending),
    .vb_pulse(vb_pulse), .vb_status(vb_status), .vb_irq(vb_irq));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // Reference cycle model built from the requirements.
  int m_run, m_h, m_v, m_pend, m_vbs;
  int w_ha, w_hf, w_hs, w_hb, w_va, w_vf, w_vs, w_vb, w_hsi, w_vsi, w_dei, w_fe;

  task automatic m_defaults();
    m_run = 0; m_h = 0; m_v = 0; m_pend = 0; m_vbs = 0;
    w_ha = 640; w_hf = 16; w_hs = 96; w_hb = 48;
    w_va = 480; w_vf = 10; w_vs = 2; w_vb = 33;
    w_hsi = 0; w_vsi = 0; w_dei = 0; w_fe = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) m_defaults();
    else begin : upd
      int htot, vtot, fe, ld, vbev;
      htot = w_ha + w_hf + w_hs + w_hb;
      vtot = w_va + w_vf + w_vs + w_vb;
      fe   = (m_run != 0) && m_h == htot - 1 && m_v == vtot - 1;
      ld   = (m_pend != 0) && (fe || (m_run == 0 && enable));
      vbev = (m_run != 0) && m_h == 0 && m_v == w_va;
      if (shadow_load) m_pend = 1; else if (ld) m_pend = 0;
      if (vbev) m_vbs = 1; else if (vb_clr) m_vbs = 0;
      if (m_run == 0) begin
        m_run = enable; m_h = 0; m_v = 0;
      end else begin
        if (fe && !enable) m_run = 0;
        if (m_h == htot - 1) begin
          m_h = 0; m_v = (m_v == vtot - 1) ? 0 : m_v + 1;
        end else m_h = m_h + 1;
      end
      if (ld) begin
        w_ha = c_ha; w_hf = c_hf; w_hs = c_hs; w_hb = c_hb;
        w_va = c_va; w_vf = c_vf; w_vs = c_vs; w_vb = c_vb;
        w_hsi = c_hsi; w_vsi = c_vsi; w_dei = c_dei; w_fe = c_fe;
      end
    end
  end

  // Compare every cycle, 1 ns after the active edge.
  always @(posedge clk) begin
    #1;
    if (rst_n) begin : cmp
      int de_r, hs_c, vs_c, hsb, vsb;
      de_r = (m_run != 0) && display_on && m_h < w_ha && m_v < w_va;
      hsb = w_ha + w_hf; vsb = w_va + w_vf;
      hs_c = (m_run != 0) && m_h >= hsb && m_h < hsb + w_hs;
      vs_c = (m_run != 0) && m_v >= vsb && m_v < vsb + w_vs;
      chk("R1/R4 hsync", hsync, hs_c ^ w_hsi);
      chk("R2/R4 vsync", vsync, vs_c ^ w_vsi);
      chk("R3/R4 de", de, de_r ^ w_dei);
      chk("R3 pix_x", pix_x, de_r ? m_h : 0);
      chk("R3 pix_y", pix_y, de_r ? m_v : 0);
      chk("R4 fall_edge", fall_edge, w_fe);
      chk("R6/R7 en_status", en_status, m_run);
      chk("R5 load_pending", load_pending, m_pend);
      chk("R8 vb_pulse", vb_pulse, (m_run != 0) && m_h == 0 && m_v == w_va);
      chk("R9 vb_status", vb_status, m_vbs);
      chk("R9 vb_irq", vb_irq, m_vbs & vb_irq_en);
      if (track_x && de_r && int'(pix_x) > max_x) max_x = pix_x;
    end
  end

  task automatic cyc(int n, bit rnd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      shadow_load = 1'b0;
      vb_clr = 1'b0;
      if (rnd) begin
        if ($urandom_range(0, 40) == 0) display_on = ~display_on;
        if ($urandom_range(0, 30) == 0) vb_clr = 1'b1;
        if ($urandom_range(0, 60) == 0) vb_irq_en = ~vb_irq_en;
      end
    end
  endtask

  task automatic pulse_load();
    @(negedge clk); shadow_load = 1'b1;
    @(negedge clk); shadow_load = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40000 && en_status; i++) @(negedge clk);
  endtask

  task automatic rand_cfg();
    c_ha = 12'($urandom_range(1, 9)); c_hf = 12'($urandom_range(1, 4));
    c_hs = 12'($urandom_range(1, 4)); c_hb = 12'($urandom_range(1, 4));
    c_va = 12'($urandom_range(1, 6)); c_vf = 12'($urandom_range(1, 3));
    c_vs = 12'($urandom_range(1, 3)); c_vb = 12'($urandom_range(1, 3));
    c_hsi = 1'($urandom); c_vsi = 1'($urandom); c_dei = 1'($urandom); c_fe = 1'($urandom);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_defaults();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 en_status", en_status, 0);
    chk("R11 load_pending", load_pending, 0);
    chk("R11 vb_status", vb_status, 0);
    chk("R11 hsync", hsync, 0);
    chk("R11 vsync", vsync, 0);
    chk("R11 de", de, 0);
    rst_n = 1'b1;
    cyc(2, 0);

    // R5/R6: load small config, then start
    pulse_load();
    chk("R5 pending after request", load_pending, 1);
    enable = 1'b1;
    cyc(1, 0);
    chk("R6 en_status after enable", en_status, 1);
    chk("R5 pending consumed at start", load_pending, 0);
    cyc(150, 0);

    // R5: shadow changes without request have no effect
    c_ha = 7; c_hs = 3; c_hsi = 1;
    cyc(120, 0);
    pulse_load();
    chk("R5 pending held mid-frame", load_pending, 1);
    cyc(200, 0);

    // R7: disable mid-frame
    cyc(13, 0);
    enable = 1'b0;
    cyc(3, 0);
    chk("R7 en_status holds after disable", en_status, 1);
    wait_idle();
    cyc(3, 0);
    chk("R7 stopped at frame end", en_status, 0);

    // Random phase
    vb_irq_en = 1'b1;
    for (int k = 0; k < 14; k++) begin
      rand_cfg();
      if ($urandom_range(0, 3) != 0) pulse_load();
      enable = 1'b1;
      cyc($urandom_range(200, 1200), 1);
      if ($urandom_range(0, 2) == 0) begin
        enable = 1'b0;
        cyc($urandom_range(1, 30), 1);
        enable = 1'b1;
      end
      cyc($urandom_range(50, 400), 1);
      if ($urandom_range(0, 1) == 0) begin
        enable = 1'b0;
        wait_idle();
        cyc(2, 1);
      end
    end

    // R10: soft reset mid-run
    enable = 1'b1; display_on = 1'b1;
    cyc(37, 0);
    pulse_load();
    enable = 1'b0;
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk("R10 en_status cleared", en_status, 0);
    chk("R10 pending cleared", load_pending, 0);
    chk("R10 vb_status cleared", vb_status, 0);
    enable = 1'b1;
    cyc(900, 0);            // default timing: partial line, hsync at 656..751
    @(negedge clk); soft_rst = 1'b1; enable = 1'b0;
    @(negedge clk); soft_rst = 1'b0;

    // R12: 4095-wide lines
    c_ha = 4095; c_hf = 1; c_hs = 1; c_hb = 1;
    c_va = 2; c_vf = 1; c_vs = 1; c_vb = 1;
    c_hsi = 0; c_vsi = 0; c_dei = 0;
    pulse_load();
    track_x = 1; max_x = 0;
    enable = 1'b1;
    cyc(4200, 0);
    enable = 1'b0;
    wait_idle();
    track_x = 0;
    chk("R12 pix_x reaches 4094", max_x, 4094);
    cyc(4, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule